// File: doc/BRIEF.md
# Memory Cycle Priority Scanner

This block decides, cycle by cycle, who owns the next memory cycle. Three kinds of requester compete: a bank of input controllers, a bank of output controllers, and one central processor. The processor is time-shared among several virtual processors. Each clock the block samples every request afresh and registers a one-hot grant. Any input controller that is asking beats everything else. An output controller wins only when no input controller asks. The processor gets the cycle only when the controller banks are both silent.

When the processor wins, the block also names the virtual processor that owns the slot. A turn pointer cycles through the virtual processors. It passes over those whose active flag is low. The pointer stays on its current owner until the instruction-complete strobe arrives. A virtual processor therefore keeps the processor across any number of cycles taken by controllers, and its instruction is never cut off part way.

None of the pins carries streamed data, so every port is a plain level or strobe, with no valid/ready handshake. The grant is a registered output that reflects the inputs sampled on the previous clock edge.

Top module: `mem_cycle_scanner`

## Requirements
- R1: At most one bit of `grant` is high in any cycle. `grant` is registered: it shows the arbitration of the inputs sampled at the previous rising edge.
- R2: If any `in_req` bit is high, the grant goes to the input bank. Grant bit i (bits 0 to N_IN-1) is raised for the lowest-numbered requesting input controller i.
- R3: If no `in_req` bit is high and some `out_req` bit is high, grant bit N_IN+j is raised for the lowest-numbered requesting output controller j.
- R4: Grant bit N_IN+N_OUT (the top bit, processor slot) is raised only when no controller is requesting and at least one `vp_active` bit is high. It is always raised in that case.
- R5: With the processor slot granted, `vp_sel` names the first active virtual processor found by scanning upward from the turn pointer, wrapping past N_VP-1 to 0. In any cycle without the processor slot, `vp_sel` is 0.
- R6: The turn pointer changes only on a sampled `instr_done` while some virtual processor is active. It then moves to one past the virtual processor selected in that same cycle, modulo N_VP. An `instr_done` while no virtual processor is active has no effect on later selection.
- R7: With no controller requests and no active virtual processor, `grant` is all zeros.
- R8: A sampled high `rst` (synchronous, active high) clears `grant` and `vp_sel` and returns the turn pointer to virtual processor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | N_IN | Request lines of the input controllers, bit i for controller i |
| out_req | input | N_OUT | Request lines of the output controllers, bit j for controller j |
| vp_active | input | N_VP | Per-virtual-processor ready flag |
| instr_done | input | 1 | One-cycle strobe: the current owner's instruction has completed |
| grant | output | N_IN+N_OUT+1 | One-hot registered grant: input bank, then output bank, then processor |
| vp_sel | output | clog2(N_VP) | Index of the virtual processor holding the processor slot |

## Verification
The assertions assume that all inputs are synchronous to `clk` and hold known values at every sampled edge. `instr_done` is treated as a single-cycle event. It may arrive in any cycle, and whether it is honoured depends only on the active flags. Another property says the selection holds steady only when the active flags stay unchanged, so mid-instruction flag changes are legal input. The stimulus drives every input once per cycle on the falling edge, from known values out of reset onward. It mixes directed sequences with random phases that change the active flags freely, so the pointer-hold property meets both its held and its unheld cases.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  // Which bank wins the arbitration in a cycle.
  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_IN   = 2'd1,
    GRP_OUT  = 2'd2,
    GRP_CPU  = 2'd3
  } grp_e;

endpackage

// File: rtl/mcs_prio_pick.sv
// Lowest-index-wins picker over a request vector.
module mcs_prio_pick #(
  parameter  int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/mcs_vp_ring.sv
// Turn pointer over the virtual processors with a cyclic search that
// passes over inactive entries. The pointer moves only on advance.
module mcs_vp_ring #(
  parameter  int N_VP = 8,
  localparam int IW   = (N_VP > 1) ? $clog2(N_VP) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_VP-1:0] vp_active,
  input  logic            advance,
  output logic            any_active,
  output logic [IW-1:0]   sel
);

  logic [IW-1:0]   ptr;
  logic [N_VP-1:0] rot;
  logic [IW-1:0]   ridx;
  logic [IW:0]     sum;
  logic [IW-1:0]   nxt;

  // Rotate so that the pointer position lands at bit 0.
  always_comb begin
    for (int i = 0; i < N_VP; i++) begin
      int j;
      j = i + int'(ptr);
      if (j >= N_VP) j = j - N_VP;
      rot[i] = vp_active[j];
    end
  end

  mcs_prio_pick #(.W(N_VP)) u_pick (
    .req (rot),
    .any (any_active),
    .idx (ridx)
  );

  // Undo the rotation, modulo N_VP.
  always_comb begin
    sum = {1'b0, ptr} + {1'b0, ridx};
    if (sum >= (IW+1)'(N_VP)) sel = IW'(sum - (IW+1)'(N_VP));
    else                      sel = IW'(sum);
    nxt = (sel == IW'(N_VP - 1)) ? '0 : sel + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                        ptr <= '0;
    else if (advance && any_active) ptr <= nxt;
  end

endmodule

// File: rtl/mem_cycle_scanner.sv
// Two-tier memory cycle arbiter: fixed priority over the controller
// banks, then a held cyclic turn among the virtual processors.
module mem_cycle_scanner
  import mcs_pkg::*;
#(
  parameter  int N_IN  = 8,
  parameter  int N_OUT = 8,
  parameter  int N_VP  = 8,
  localparam int GW    = N_IN + N_OUT + 1,
  localparam int VW    = (N_VP > 1) ? $clog2(N_VP) : 1,
  localparam int IIW   = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int OIW   = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  in_req,
  input  logic [N_OUT-1:0] out_req,
  input  logic [N_VP-1:0]  vp_active,
  input  logic             instr_done,
  output logic [GW-1:0]    grant,
  output logic [VW-1:0]    vp_sel
);

  logic           in_any, out_any, vp_any;
  logic [IIW-1:0] in_idx;
  logic [OIW-1:0] out_idx;
  logic [VW-1:0]  ring_sel;
  grp_e           grp;
  logic [GW-1:0]  nxt_grant;
  logic [VW-1:0]  nxt_sel;

  mcs_prio_pick #(.W(N_IN)) u_in_pick (
    .req (in_req),
    .any (in_any),
    .idx (in_idx)
  );

  mcs_prio_pick #(.W(N_OUT)) u_out_pick (
    .req (out_req),
    .any (out_any),
    .idx (out_idx)
  );

  mcs_vp_ring #(.N_VP(N_VP)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .vp_active  (vp_active),
    .advance    (instr_done),
    .any_active (vp_any),
    .sel        (ring_sel)
  );

  always_comb begin
    if (in_any)       grp = GRP_IN;
    else if (out_any) grp = GRP_OUT;
    else if (vp_any)  grp = GRP_CPU;
    else              grp = GRP_NONE;
  end

  always_comb begin
    nxt_grant = '0;
    nxt_sel   = '0;
    case (grp)
      GRP_IN:  nxt_grant[int'(in_idx)] = 1'b1;
      GRP_OUT: nxt_grant[N_IN + int'(out_idx)] = 1'b1;
      GRP_CPU: begin
        nxt_grant[GW-1] = 1'b1;
        nxt_sel         = ring_sel;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant  <= '0;
      vp_sel <= '0;
    end else begin
      grant  <= nxt_grant;
      vp_sel <= nxt_sel;
    end
  end

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
  parameter  int N_IN  = 8,
  parameter  int N_OUT = 8,
  parameter  int N_VP  = 8,
  localparam int GW    = N_IN + N_OUT + 1,
  localparam int VW    = (N_VP > 1) ? $clog2(N_VP) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic [N_IN-1:0]  in_req,
  input logic [N_OUT-1:0] out_req,
  input logic [N_VP-1:0]  vp_active,
  input logic             instr_done,
  input logic [GW-1:0]    grant,
  input logic [VW-1:0]    vp_sel
);

  logic [N_VP-1:0] act_d;
  logic            done_d;
  logic            hist_ok;

  always_ff @(posedge clk) begin
    act_d  <= vp_active;
    done_d <= instr_done;
    if (rst) hist_ok <= 1'b0;
    else     hist_ok <= 1'b1;
  end

  wire io_quiet = ~|in_req && ~|out_req;

  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_in_first_r2: assert property (@(posedge clk) disable iff (rst)
    |in_req |=> |grant[N_IN-1:0]);

  p_out_second_r3: assert property (@(posedge clk) disable iff (rst)
    (~|in_req && |out_req) |=> |grant[N_IN +: N_OUT]);

  p_cpu_last_r4: assert property (@(posedge clk) disable iff (rst)
    (io_quiet && |vp_active) |=> grant[GW-1]);

  p_sel_active_r5: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && grant[GW-1]) |-> act_d[vp_sel]);

  p_sel_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !grant[GW-1] |-> (vp_sel == '0));

  p_turn_held_r6: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && grant[GW-1] && !done_d && vp_active == act_d && io_quiet)
      |=> (vp_sel == $past(vp_sel)));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (io_quiet && ~|vp_active) |=> (grant == '0));

  p_reset_r8: assert property (@(posedge clk)
    rst |=> (grant == '0 && vp_sel == '0));

endmodule

bind mem_cycle_scanner mcs_checker #(
  .N_IN  (N_IN),
  .N_OUT (N_OUT),
  .N_VP  (N_VP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_req     (in_req),
  .out_req    (out_req),
  .vp_active  (vp_active),
  .instr_done (instr_done),
  .grant      (grant),
  .vp_sel     (vp_sel)
);

// File: tb/mem_cycle_scanner_tb.sv
module mem_cycle_scanner_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_req = '0;
  logic [7:0]  out_req = '0;
  logic [7:0]  vp_active = '0;
  logic        instr_done = 1'b0;
  logic [16:0] grant;
  logic [2:0]  vp_sel;

  int n_cmp = 0;
  int n_bad = 0;
  string phase_tag = "";

  // reference model state
  int          m_ptr = 0;
  logic [16:0] e_grant = '0;
  int          e_sel = 0;
  string       e_tag = "R8";

  always #5 clk = ~clk;

  mem_cycle_scanner u_dut (
    .clk(clk), .rst(rst), .in_req(in_req), .out_req(out_req),
    .vp_active(vp_active), .instr_done(instr_done),
    .grant(grant), .vp_sel(vp_sel)
  );

  function automatic int lowest8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int pick_vp(input logic [7:0] act, input int p);
    for (int k = 0; k < 8; k++) if (act[(p + k) % 8]) return (p + k) % 8;
    return 0;
  endfunction

  always @(posedge clk) begin
    int s;
    if (rst) begin
      e_grant = '0; e_sel = 0; m_ptr = 0; e_tag = "R8";
    end else begin
      s = pick_vp(vp_active, m_ptr);
      e_grant = '0; e_sel = 0;
      if (in_req != 0) begin
        e_grant[lowest8(in_req)] = 1'b1; e_tag = "R2";
      end else if (out_req != 0) begin
        e_grant[8 + lowest8(out_req)] = 1'b1; e_tag = "R3";
      end else if (vp_active != 0) begin
        e_grant[16] = 1'b1; e_sel = s; e_tag = "R5";
      end else begin
        e_tag = "R7";
      end
      if (instr_done && vp_active != 0) m_ptr = (s + 1) % 8;
    end
  end

  task automatic compare();
    string t;
    t = (phase_tag != "" && e_tag != "R8") ? phase_tag : e_tag;
    n_cmp++;
    if (grant !== e_grant) begin
      n_bad++;
      $display("FAIL %s grant actual=%b expected=%b", t, grant, e_grant);
    end
    n_cmp++;
    if (int'(vp_sel) != e_sel) begin
      n_bad++;
      $display("FAIL %s vp_sel actual=%0d expected=%0d", t, vp_sel, e_sel);
    end
    n_cmp++;
    if ($countones(grant) > 1) begin
      n_bad++;
      $display("FAIL R1 grant actual=%b expected=at most one bit", grant);
    end
  endtask

  task automatic cyc(input logic r, input logic [7:0] ir, input logic [7:0] orq,
                     input logic [7:0] act, input logic dn);
    @(negedge clk);
    compare();
    rst = r; in_req = ir; out_req = orq; vp_active = act; instr_done = dn;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R8: reset state
    cyc(1, 8'h00, 8'h00, 8'h00, 0);
    cyc(1, 8'hA0, 8'h18, 8'hFF, 1);
    // R7: idle
    cyc(0, 8'h00, 8'h00, 8'h00, 0);
    cyc(0, 8'h00, 8'h00, 8'h00, 1);
    // R2: inputs win, lowest index
    cyc(0, 8'hA0, 8'h18, 8'h24, 0);
    cyc(0, 8'h81, 8'hFF, 8'hFF, 0);
    // R3: outputs when inputs idle
    cyc(0, 8'h00, 8'h18, 8'h24, 0);
    cyc(0, 8'h00, 8'h80, 8'h24, 0);
    // R4/R5: processor slot, search from pointer 0 finds VP 2
    phase_tag = "R5";
    cyc(0, 8'h00, 8'h00, 8'h24, 0);
    cyc(0, 8'h00, 8'h00, 8'h24, 0);
    // R6: hold without done, then advance 2 -> 5 -> wrap to 2
    phase_tag = "R6";
    cyc(0, 8'h00, 8'h00, 8'h24, 1);
    cyc(0, 8'h00, 8'h00, 8'h24, 0);
    cyc(0, 8'h00, 8'h00, 8'h24, 1);
    cyc(0, 8'h00, 8'h00, 8'h24, 0);
    // controllers steal cycles, owner kept
    cyc(0, 8'h02, 8'h00, 8'h24, 0);
    cyc(0, 8'h00, 8'h40, 8'h24, 0);
    cyc(0, 8'h00, 8'h00, 8'h24, 0);
    cyc(0, 8'h00, 8'h00, 8'h24, 0);
    // done with nothing active: no effect on later choice
    cyc(0, 8'h00, 8'h00, 8'h00, 1);
    cyc(0, 8'h00, 8'h00, 8'hFF, 0);
    cyc(0, 8'h00, 8'h00, 8'hFF, 1);
    cyc(0, 8'h00, 8'h00, 8'hFF, 1);
    cyc(0, 8'h00, 8'h00, 8'h80, 1);
    cyc(0, 8'h00, 8'h00, 8'h01, 0);
    cyc(0, 8'h00, 8'h00, 8'h01, 0);
    // random phase, tags from expected winner
    phase_tag = "";
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      a = ($urandom % 6 == 0) ? 8'($urandom) : vp_active;
      cyc(0, ($urandom % 4 == 0) ? 8'($urandom) : 8'h00,
             ($urandom % 4 == 0) ? 8'($urandom) : 8'h00,
             a, ($urandom % 3 == 0));
    end
    // R8: reset mid-run returns pointer to 0
    cyc(1, 8'h00, 8'h00, 8'hFF, 0);
    phase_tag = "R8";
    cyc(0, 8'h00, 8'h00, 8'hFF, 0);
    cyc(0, 8'h00, 8'h00, 8'hFF, 0);
    cyc(0, 8'h00, 8'h00, 8'h00, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule